// File: doc/BRIEF.md
# SMI Cause Status and Aggregation Register

This block is the 32-bit status word that tells system-management firmware why a system-management interrupt was raised, and it drives the active-low interrupt line itself. Three causes are sticky: an SMBus-side event, a periodic tick and an access to the embedded-controller I/O ports. Each one is latched into a bit that firmware clears by writing a one, and it raises the interrupt only while its own enable input is high. The other causes are derived. Three summary bits OR the enabled members of external status groups: general-purpose event group 0, general-purpose event group 1 with a per-bit routing mask, and the device-trap sources. Two further bits pass through the level requests of the serial-IRQ decoder and the watchdog logic. These derived bits are already qualified by their sources, so they raise the interrupt with no enable of their own.

The register sits at offset 34h of the power-management I/O window and is reached through a simple address, write-strobe, write-data and read-data port. The SMBus event arrives from a slow 64 kHz domain. Inside the block it passes through a two-flop synchronizer and a rising-edge detector, so each assertion in the slow domain latches the bit once. The port-access source comes from a snoop of the I/O address bus.

Top module: `smi_stat_agg`

## Requirements
- R1: After reset the word at offset 34h reads 0 and `smi_n` is high. Bits 31:17 and 8:0 always read 0, and a read at any other offset returns 0.
- R2: Bits 16, 14 and 11 are cleared by a write at offset 34h with a 1 in their position. A 0 in that position, or a write at any other offset, leaves them unchanged.
- R3: Bit 11 is set by an `io_strb` cycle whose `io_addr` is 0062h or 0066h. Any other address leaves it unchanged.
- R4: Bit 14 is set one cycle after a `per_tick` pulse. A rising level on `smb_evt` sets bit 16 on the third clock edge after the change. A level that stays high sets bit 16 only once.
- R5: `smi_n` is low while bit 16, 14 or 11 is set together with its enable (`en_smb`, `en_per` or `en_mc`). Such a bit with its enable low does not pull `smi_n` low.
- R6: Bit 9 is the OR of `gpe0_sts & gpe0_en`. Bit 10 is the OR of `gpe1_sts & gpe1_en & gpe1_route`. Bit 12 is the OR of `trap_sts & trap_en`. When any of these bits is 1, `smi_n` is low.
- R7: Bit 15 follows `sirq_req` and bit 13 follows `tco_req` with no latching. When either is 1, `smi_n` is low.
- R8: When a set event and a write-one clear hit the same sticky bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Byte offset within the power-management window |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data (ones clear sticky bits) |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| io_strb | input | 1 | Valid I/O cycle on the snooped bus |
| io_addr | input | 16 | I/O port address of the snooped cycle |
| per_tick | input | 1 | Periodic tick pulse, core domain |
| smb_evt | input | 1 | SMBus event level from the 64 kHz domain |
| sirq_req | input | 1 | Serial-IRQ decoder request level |
| tco_req | input | 1 | Watchdog logic request level |
| en_smb | input | 1 | Enable for bit 16 |
| en_per | input | 1 | Enable for bit 14 |
| en_mc | input | 1 | Enable for bit 11 |
| gpe0_sts | input | 16 | Group 0 event status |
| gpe0_en | input | 16 | Group 0 event enable |
| gpe1_sts | input | 16 | Group 1 event status |
| gpe1_en | input | 16 | Group 1 event enable |
| gpe1_route | input | 16 | Group 1 route-to-SMI mask |
| trap_sts | input | 8 | Device-trap status |
| trap_en | input | 8 | Device-trap enable |
| smi_n | output | 1 | Active-low system-management interrupt |

## Verification
A source event and a firmware write-one clear can land on the same sticky bit in the same clock cycle. The bench provokes this two ways. It raises `per_tick` in the cycle that carries a write of 1 to bit 14, and it issues an `io_strb` to 0066h in the cycle that carries a write of 1 to bit 11. After that edge it reads the word and expects both bits still set, since a set that loses to the clear would drop an interrupt cause. The summary bits and pass-through bits are walked as a vector table. Each row's expected bits and interrupt level are written out by hand from the requirements.

// File: rtl/smi_pkg.sv
// Package: shared bit positions and offsets for the SMI status word.
// Assumes byte offsets within an 8-bit power-management window.
package smi_pkg;
    localparam logic [7:0] STS_OFS  = 8'h34;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned N_STICKY = 3;
    // sticky slots: 0 = SMBus event, 1 = periodic, 2 = port snoop
    localparam int unsigned POS_SMB  = 16;
    localparam int unsigned POS_SIRQ = 15;
    localparam int unsigned POS_PER  = 14;
    localparam int unsigned POS_TCO  = 13;
    localparam int unsigned POS_TRAP = 12;
    localparam int unsigned POS_MC   = 11;
    localparam int unsigned POS_GPE1 = 10;
    localparam int unsigned POS_GPE0 = 9;
    localparam int unsigned STICKY_POS [N_STICKY] = '{POS_SMB, POS_PER, POS_MC};
endpackage

// File: rtl/smi_sticky_bit.sv
// Module: one write-one-to-clear status bit where a set beats a clear
// in the same cycle. Assumes set_i and clr_i are synchronous to clk.
module smi_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // latch the event; clear only when no event arrives this cycle
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) set_i |=> q_o); // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (clr_i && !set_i) |=> !q_o); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (rst_n && !set_i && !clr_i) |=> $stable(q_o)); // R2
endmodule

// File: rtl/smi_edge_sync.sv
// Module: brings a slow-domain level into clk through a flop chain and
// emits a one-cycle pulse on each rising level. Assumes the source level
// stays high for several clk cycles, as a 64 kHz source does.
module smi_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    localparam int unsigned LAST = STAGES - 1;
    logic [LAST:0] chain_q;
    logic          prev_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // each stage resamples the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[gi] <= 1'b0;
                else if (gi == 0) chain_q[gi] <= lvl_i;
                else chain_q[gi] <= chain_q[(gi == 0) ? 0 : gi - 1];
            end
        end
    endgenerate

    // remember the last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    assign rise_o = chain_q[LAST] & ~prev_q;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rise_o |=> !rise_o); // R4
endmodule

// File: rtl/smi_port_snoop.sv
// Module: flags an I/O cycle to either of two fixed ports.
// Assumes io_strb marks one valid address per cycle.
module smi_port_snoop #(
    parameter int unsigned   AW     = 16,
    parameter logic [AW-1:0] PORT_A = 16'h0062,
    parameter logic [AW-1:0] PORT_B = 16'h0066
) (
    input  logic          io_strb,
    input  logic [AW-1:0] io_addr,
    output logic          hit_o
);
    // compare the address with both watched ports
    always_comb hit_o = io_strb && ((io_addr == PORT_A) || (io_addr == PORT_B));
endmodule

// File: rtl/smi_group_or.sv
// Module: ORs a status group through its enable, and optionally through a
// routing mask when USE_MASK is 1. Purely combinational.
module smi_group_or #(
    parameter int unsigned W        = 16,
    parameter bit          USE_MASK = 1'b0
) (
    input  logic [W-1:0] sts_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] mask_i,
    output logic         any_o
);
    generate
        if (USE_MASK) begin : g_masked
            // only routed members count
            always_comb any_o = |(sts_i & en_i & mask_i);
        end else begin : g_plain
            logic unused_mask;
            always_comb unused_mask = ^mask_i;
            // every enabled member counts
            always_comb any_o = |(sts_i & en_i);
        end
    endgenerate
endmodule

// File: rtl/smi_stat_agg.sv
// Module: top of the SMI status word. It latches three sticky causes, derives
// five read-only cause bits, decodes register writes at offset 34h and drives
// the active-low interrupt. Assumes a single-cycle write strobe and that the
// group inputs are already in the clk domain.
module smi_stat_agg
    import smi_pkg::*;
#(
    parameter int unsigned G0W = 16,
    parameter int unsigned G1W = 16,
    parameter int unsigned TW  = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [7:0]     reg_addr,
    input  logic           reg_wr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic           io_strb,
    input  logic [15:0]    io_addr,
    input  logic           per_tick,
    input  logic           smb_evt,
    input  logic           sirq_req,
    input  logic           tco_req,
    input  logic           en_smb,
    input  logic           en_per,
    input  logic           en_mc,
    input  logic [G0W-1:0] gpe0_sts,
    input  logic [G0W-1:0] gpe0_en,
    input  logic [G1W-1:0] gpe1_sts,
    input  logic [G1W-1:0] gpe1_en,
    input  logic [G1W-1:0] gpe1_route,
    input  logic [TW-1:0]  trap_sts,
    input  logic [TW-1:0]  trap_en,
    output logic           smi_n
);
    logic                wr_hit;
    logic                smb_rise, mc_hit;
    logic                gpe0_any, gpe1_any, trap_any;
    logic [N_STICKY-1:0] st_set, st_en, st_clr, st_q;
    logic [WORD_W-1:0]   sts_word;
    logic                sticky_cause, derived_cause;
    logic                unused_wdata;

    // write decode for the status word
    always_comb wr_hit = reg_wr && (reg_addr == STS_OFS);
    always_comb unused_wdata = ^{reg_wdata[31:17], reg_wdata[15], reg_wdata[13:12], reg_wdata[10:0]};

    smi_edge_sync #(.STAGES(SYNC_STAGES)) u_smb_sync (
        .clk(clk), .rst_n(rst_n), .lvl_i(smb_evt), .rise_o(smb_rise));

    smi_port_snoop #(.AW(16), .PORT_A(16'h0062), .PORT_B(16'h0066)) u_snoop (
        .io_strb(io_strb), .io_addr(io_addr), .hit_o(mc_hit));

    smi_group_or #(.W(G0W), .USE_MASK(1'b0)) u_gpe0 (
        .sts_i(gpe0_sts), .en_i(gpe0_en), .mask_i({G0W{1'b1}}), .any_o(gpe0_any));
    smi_group_or #(.W(G1W), .USE_MASK(1'b1)) u_gpe1 (
        .sts_i(gpe1_sts), .en_i(gpe1_en), .mask_i(gpe1_route), .any_o(gpe1_any));
    smi_group_or #(.W(TW), .USE_MASK(1'b0)) u_trap (
        .sts_i(trap_sts), .en_i(trap_en), .mask_i({TW{1'b1}}), .any_o(trap_any));

    // route each source and enable to its sticky slot
    always_comb begin
        st_set = {mc_hit, per_tick, smb_rise};
        st_en  = {en_mc, en_per, en_smb};
    end

    genvar si;
    generate
        for (si = 0; si < N_STICKY; si++) begin : g_sticky
            // a one in the bit's own position clears it
            always_comb st_clr[si] = wr_hit && reg_wdata[STICKY_POS[si]];
            smi_sticky_bit u_bit (
                .clk(clk), .rst_n(rst_n), .set_i(st_set[si]),
                .clr_i(st_clr[si]), .q_o(st_q[si]));
            AST_ENABLED_CAUSE_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n) (st_q[si] && st_en[si]) |-> !smi_n); // R5
        end
    endgenerate

    // assemble the status word; unlisted bits stay zero
    always_comb begin
        sts_word           = '0;
        sts_word[POS_SMB]  = st_q[0];
        sts_word[POS_PER]  = st_q[1];
        sts_word[POS_MC]   = st_q[2];
        sts_word[POS_SIRQ] = sirq_req;
        sts_word[POS_TCO]  = tco_req;
        sts_word[POS_TRAP] = trap_any;
        sts_word[POS_GPE1] = gpe1_any;
        sts_word[POS_GPE0] = gpe0_any;
    end

    // read mux: only the status offset returns data
    always_comb reg_rdata = (reg_addr == STS_OFS) ? sts_word : '0;

    // interrupt: enabled sticky causes or any derived cause
    always_comb begin
        sticky_cause  = |(st_q & st_en);
        derived_cause = gpe0_any | gpe1_any | trap_any | sirq_req | tco_req;
        smi_n         = ~(sticky_cause | derived_cause);
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (reg_rdata[31:17] == '0) && (reg_rdata[8:0] == '0)); // R1
    AST_SNOOP_SETS_MC: assert property (@(posedge clk) disable iff (!rst_n) mc_hit |=> st_q[2]); // R3
    AST_DERIVED_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n) (gpe0_any || gpe1_any || trap_any) |-> !smi_n); // R6
    AST_PASSTHRU_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n) (sirq_req || tco_req) |-> !smi_n); // R7
endmodule

// File: tb/smi_stat_agg_tb.sv
module smi_stat_agg_tb;
    localparam int CLK_P = 10;

    logic        clk = 0, rst_n = 0;
    logic [7:0]  reg_addr = 8'h34;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        io_strb = 0;
    logic [15:0] io_addr = 0;
    logic        per_tick = 0, smb_evt = 0, sirq_req = 0, tco_req = 0;
    logic        en_smb = 0, en_per = 0, en_mc = 0;
    logic [15:0] gpe0_sts = 0, gpe0_en = 0, gpe1_sts = 0, gpe1_en = 0, gpe1_route = 0;
    logic [7:0]  trap_sts = 0, trap_en = 0;
    logic        smi_n;
    int          total = 0, bad = 0;
    bit          done = 0;

    always #(CLK_P/2) clk = ~clk;

    smi_stat_agg u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_strb(io_strb),
        .io_addr(io_addr), .per_tick(per_tick), .smb_evt(smb_evt),
        .sirq_req(sirq_req), .tco_req(tco_req), .en_smb(en_smb),
        .en_per(en_per), .en_mc(en_mc), .gpe0_sts(gpe0_sts), .gpe0_en(gpe0_en),
        .gpe1_sts(gpe1_sts), .gpe1_en(gpe1_en), .gpe1_route(gpe1_route),
        .trap_sts(trap_sts), .trap_en(trap_en), .smi_n(smi_n));

    // row: group inputs, pass-through levels, expected {b15,b13,b12,b10,b9}, expected smi_n
    typedef struct packed {
        logic [15:0] g0s, g0e, g1s, g1e, g1r;
        logic [7:0]  ts, te;
        logic        ser, tco;
        logic [4:0]  exp_bits;
        logic        exp_smin;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b0, 5'b00000, 1'b1},
        '{16'h0001, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b0, 5'b00001, 1'b0},
        '{16'h0001, 16'h0002, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b0, 5'b00000, 1'b1},
        '{16'h0000, 16'h0000, 16'h0010, 16'h0010, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b0, 5'b00000, 1'b1},
        '{16'h0000, 16'h0000, 16'h0010, 16'h0010, 16'h0010, 8'h00, 8'h00, 1'b0, 1'b0, 5'b00010, 1'b0},
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'h80, 8'h80, 1'b0, 1'b0, 5'b00100, 1'b0},
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'h80, 8'h7F, 1'b0, 1'b0, 5'b00000, 1'b1},
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00, 1'b1, 1'b0, 5'b10000, 1'b0},
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b1, 5'b01000, 1'b0},
        '{16'h8000, 16'h8000, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b1, 5'b01001, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0; reg_addr = 8'h34; reg_wdata = 0;
    endtask

    task automatic snoop(input logic [15:0] a);
        @(negedge clk); io_addr = a; io_strb = 1;
        @(negedge clk); io_strb = 0;
    endtask

    task automatic tick();
        @(negedge clk); per_tick = 1;
        @(negedge clk); per_tick = 0;
    endtask

    function automatic logic [31:0] rd();
        return reg_rdata;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset word", rd(), 32'h0);
        chk("R1 reset smi_n", {31'h0, smi_n}, 32'h1);
        rst_n = 1;

        // table walk over derived bits
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            gpe0_sts = VECS[i].g0s; gpe0_en = VECS[i].g0e;
            gpe1_sts = VECS[i].g1s; gpe1_en = VECS[i].g1e; gpe1_route = VECS[i].g1r;
            trap_sts = VECS[i].ts;  trap_en = VECS[i].te;
            sirq_req = VECS[i].ser; tco_req = VECS[i].tco;
            #1;
            chk("R6/R7 derived bits", {27'h0, rd()[15], rd()[13], rd()[12], rd()[10], rd()[9]},
                {27'h0, VECS[i].exp_bits});
            chk("R6/R7 smi_n", {31'h0, smi_n}, {31'h0, VECS[i].exp_smin});
        end
        @(negedge clk);
        gpe0_sts = 0; gpe0_en = 0; gpe1_sts = 0; gpe1_en = 0; gpe1_route = 0;
        trap_sts = 0; trap_en = 0; sirq_req = 0; tco_req = 0;

        // R3 port snoop
        snoop(16'h0063); #1 chk("R3 other port ignored", rd(), 32'h0);
        snoop(16'h0062); #1 chk("R3 port 62h sets bit 11", rd(), 32'h0000_0800);
        chk("R5 disabled bit 11 no smi", {31'h0, smi_n}, 32'h1);
        en_mc = 1; #1 chk("R5 enabled bit 11 smi low", {31'h0, smi_n}, 32'h0);
        wr(8'h34, 32'hFFFF_F7FF); #1 chk("R2 zero write keeps bit 11", rd(), 32'h0000_0800);
        wr(8'h30, 32'h0000_0800); #1 chk("R2 other offset keeps bit 11", rd(), 32'h0000_0800);
        reg_addr = 8'h30; #1 chk("R1 other offset reads zero", rd(), 32'h0);
        reg_addr = 8'h34;
        wr(8'h34, 32'h0000_0800); #1 chk("R2 w1c bit 11", rd(), 32'h0);
        chk("R5 smi_n released", {31'h0, smi_n}, 32'h1);
        snoop(16'h0066); #1 chk("R3 port 66h sets bit 11", rd(), 32'h0000_0800);

        // R8 same-cycle set and clear on bit 11
        @(negedge clk); io_addr = 16'h0066; io_strb = 1;
        reg_addr = 8'h34; reg_wdata = 32'h0000_0800; reg_wr = 1;
        @(negedge clk); io_strb = 0; reg_wr = 0; reg_wdata = 0;
        #1 chk("R8 snoop beats clear", rd(), 32'h0000_0800);
        wr(8'h34, 32'h0000_0800); en_mc = 0;

        // R4 periodic
        tick(); #1 chk("R4 tick sets bit 14", rd(), 32'h0000_4000);
        chk("R5 bit 14 disabled", {31'h0, smi_n}, 32'h1);
        en_per = 1; #1 chk("R5 bit 14 enabled", {31'h0, smi_n}, 32'h0);
        @(negedge clk); per_tick = 1; reg_wdata = 32'h0000_4000; reg_wr = 1;
        @(negedge clk); per_tick = 0; reg_wr = 0; reg_wdata = 0;
        #1 chk("R8 tick beats clear", rd(), 32'h0000_4000);
        wr(8'h34, 32'h0000_4000); #1 chk("R2 w1c bit 14", rd(), 32'h0);
        en_per = 0;

        // R4 slow-domain SMBus event: three edges to reach the status bit
        @(negedge clk); smb_evt = 1;
        @(posedge clk); @(posedge clk); #1;
        chk("R4 bit 16 not yet set", rd(), 32'h0);
        @(posedge clk); #1;
        chk("R4 bit 16 set on third edge", rd(), 32'h0001_0000);
        en_smb = 1; #1 chk("R5 bit 16 enabled", {31'h0, smi_n}, 32'h0);
        wr(8'h34, 32'h0001_0000);
        repeat (5) @(negedge clk);
        #1 chk("R4 held level sets once", rd(), 32'h0);
        chk("R5 smi_n after clear", {31'h0, smi_n}, 32'h1);
        smb_evt = 0;
        repeat (4) @(negedge clk);
        smb_evt = 1;
        repeat (4) @(negedge clk);
        #1 chk("R4 new rise sets again", rd(), 32'h0001_0000);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule